// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

This block is one logic cell of a programmable logic array. It takes a set of data inputs and forms a true literal and a complemented literal from each. A programmable AND plane builds a few product terms from those literals. An OR gate sums the product terms, together with any terms borrowed from neighbouring cells. A polarity XOR follows the sum, and then a storage element whose behaviour is set by configuration. Each cell exposes its own product terms so that its neighbours can borrow them.

All behaviour comes from one static configuration word. That word holds a literal mask for each product term, an enable bit for each borrowed term, a polarity bit, a two-bit storage mode and an output select. The output is either the polarity-adjusted sum taken directly or the value held in the storage element. The storage element can act as a D, T or JK flip-flop, or as a latch that is transparent while the clock is high.

Top module: `cfg_macrocell`

## Requirements
- R1: Input i gives literal bit 2i (true) and literal bit 2i+1 (complement). Term t is the AND of the literals selected by mask bits cfg_i[16t+15:16t]. A term whose mask is all zero evaluates to 0.
- R2: The sum is the OR of all five local terms when the storage mode is not JK.
- R3: Borrowed term shr_i[s] joins the OR only when enable bit cfg_i[80+s] is 1. A borrowed term whose enable bit is 0 has no effect.
- R4: Polarity bit cfg_i[84] is XORed with the sum, so a value of 1 inverts it.
- R5: Output-select bit cfg_i[87]: a value of 0 drives the polarity-adjusted sum on out_o, and a value of 1 drives the stored value.
- R6: Mode cfg_i[86:85]=00 (D): on each rising clock edge, the stored value takes the polarity-adjusted sum.
- R7: Mode 01 (T): on a rising edge, the stored value toggles when the sum is 1 and holds when it is 0.
- R8: Mode 10 (JK): J is the polarity-adjusted sum and K is local term 4. Term 4 is then left out of the OR. On each rising edge the stored value follows the JK rules: set, reset, toggle or hold.
- R9: Mode 11 (latch): the stored value follows the sum while clk_i is high and holds the value present at the falling edge while clk_i is low.
- R10: While rst_ni is low, the stored value is 0 in every mode, and it clears without waiting for a clock edge.
- R11: pt_o[t] carries local term t unchanged in every mode, including term 4 in JK mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also the enable level of latch mode |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | 8 | Data inputs |
| shr_i | input | 4 | Product terms borrowed from neighbouring cells |
| cfg_i | input | 88 | Configuration word |
| pt_o | output | 5 | Local product terms, exported for sharing |
| out_o | output | 1 | Cell output |

## Verification
A corrupted stored bit shows at out_o, in registered mode, on the first rising edge after the fault, or at once in latch mode while the clock is high. A T or JK cell holding a wrong value keeps that error through every later toggle, so a single cycle is enough to reveal it. A mask or literal-order error shows only at the input pattern that exercises the affected term. For that reason the combinational vectors each isolate one literal or one borrowed term, and pt_o exposes every term directly.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  typedef enum logic [1:0] {
    MODE_D     = 2'b00,
    MODE_T     = 2'b01,
    MODE_JK    = 2'b10,
    MODE_LATCH = 2'b11
  } store_mode_e;
endpackage

// File: rtl/mc_and_plane.sv
`timescale 1ns/1ps
module mc_and_plane #(
  parameter int N_IN = 8,
  parameter int N_PT = 5,
  localparam int N_LIT = 2 * N_IN
) (
  input  logic [N_IN-1:0]        in_i,
  input  logic [N_PT*N_LIT-1:0]  mask_i,
  output logic [N_PT-1:0]        pt_o
);
  logic [N_LIT-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = in_i[i];
    assign lit[2*i+1] = ~in_i[i];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_LIT-1:0] m;
    assign m = mask_i[t*N_LIT +: N_LIT];
    // empty mask yields 0, not the AND identity
    assign pt_o[t] = (|m) & (&(~m | lit));
  end
endmodule

// File: rtl/mc_sum.sv
`timescale 1ns/1ps
module mc_sum #(
  parameter int N_PT  = 5,
  parameter int N_SHR = 4
) (
  input  logic [N_PT-1:0]  pt_i,
  input  logic [N_SHR-1:0] shr_i,
  input  logic [N_SHR-1:0] sen_i,
  input  logic             pol_i,
  input  logic             jk_i,
  output logic             x_o
);
  logic [N_PT-1:0] local_pt;
  logic            sum;

  always_comb begin
    local_pt = pt_i;
    if (jk_i) local_pt[N_PT-1] = 1'b0; // last term serves as K
    sum = (|local_pt) | (|(shr_i & sen_i));
    x_o = sum ^ pol_i;
  end
endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store
  import mc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  store_mode_e mode_i,
  input  logic        d_i,
  input  logic        k_i,
  output logic        q_o
);
  logic ff_q;
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= 1'b0;
    end else begin
      unique case (mode_i)
        MODE_T:  ff_q <= ff_q ^ d_i;
        MODE_JK: ff_q <= (d_i & ~ff_q) | (~k_i & ff_q);
        default: ff_q <= d_i;
      endcase
    end
  end

  // latch modelled as value captured at the falling edge plus a clock-high bypass
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= d_i;
  end

  always_comb begin
    if (mode_i == MODE_LATCH) q_o = rst_ni & (clk_i ? d_i : hold_q);
    else                      q_o = ff_q;
  end

  // R6
  d_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_D) |=> (ff_q == $past(d_i)));
  // R7
  t_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_T && d_i) |=> (ff_q != $past(ff_q)));
  // R8
  jk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_JK && !d_i && !k_i) |=> $stable(ff_q));
  // R8
  jk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_JK && d_i && !k_i) |=> ff_q);
  // R8
  jk_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_JK && !d_i && k_i) |=> !ff_q);
endmodule

// File: rtl/cfg_macrocell.sv
`timescale 1ns/1ps
module cfg_macrocell
  import mc_pkg::*;
#(
  parameter  int N_IN     = 8,
  parameter  int N_PT     = 5,
  parameter  int N_SHR    = 4,
  localparam int N_LIT    = 2 * N_IN,
  localparam int MASK_W   = N_PT * N_LIT,
  localparam int SEN_LO   = MASK_W,
  localparam int POL_BIT  = SEN_LO + N_SHR,
  localparam int MODE_LO  = POL_BIT + 1,
  localparam int OSEL_BIT = MODE_LO + 2,
  localparam int CFG_W    = OSEL_BIT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_SHR-1:0] shr_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [N_PT-1:0]  pt_o,
  output logic             out_o
);
  store_mode_e mode;
  logic        x;
  logic        q;

  assign mode = store_mode_e'(cfg_i[MODE_LO +: 2]);

  mc_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_i   (in_i),
    .mask_i (cfg_i[MASK_W-1:0]),
    .pt_o   (pt_o)
  );

  mc_sum #(.N_PT(N_PT), .N_SHR(N_SHR)) u_sum (
    .pt_i  (pt_o),
    .shr_i (shr_i),
    .sen_i (cfg_i[SEN_LO +: N_SHR]),
    .pol_i (cfg_i[POL_BIT]),
    .jk_i  (mode == MODE_JK),
    .x_o   (x)
  );

  mc_store u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .d_i    (x),
    .k_i    (pt_o[N_PT-1]),
    .q_o    (q)
  );

  assign out_o = cfg_i[OSEL_BIT] ? q : x;

  // R10
  rst_clear_chk: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni) && cfg_i[OSEL_BIT]) |-> !out_o);
endmodule

// File: tb/sim_cfg_macrocell.sv
`timescale 1ns/1ps
module sim_cfg_macrocell;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  in_v = '0;
  logic [3:0]  shr_v = '0;
  logic [87:0] cfg = '0;
  logic [4:0]  pt;
  logic        out;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_macrocell u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_i(in_v), .shr_i(shr_v),
    .cfg_i(cfg), .pt_o(pt), .out_o(out)
  );

  // fields: m0[49:34] m1[33:18] sen[17:14] pol[13] in[12:5] shr[4:1] exp[0]
  localparam logic [49:0] VEC [14] = '{
    {16'h0000, 16'h0000, 4'h0, 1'b0, 8'h00, 4'h0, 1'b0}, // R1 empty masks
    {16'h0000, 16'h0000, 4'h0, 1'b1, 8'h00, 4'h0, 1'b1}, // R4
    {16'h0001, 16'h0000, 4'h0, 1'b0, 8'h01, 4'h0, 1'b1}, // R1 true literal
    {16'h0001, 16'h0000, 4'h0, 1'b0, 8'h00, 4'h0, 1'b0}, // R1
    {16'h0009, 16'h0000, 4'h0, 1'b0, 8'h01, 4'h0, 1'b1}, // R1 in0 & ~in1
    {16'h0009, 16'h0000, 4'h0, 1'b0, 8'h03, 4'h0, 1'b0}, // R1
    {16'h0003, 16'h0000, 4'h0, 1'b0, 8'h01, 4'h0, 1'b0}, // R1 contradiction
    {16'h0001, 16'h0010, 4'h0, 1'b0, 8'h04, 4'h0, 1'b1}, // R2 second term
    {16'h0000, 16'h0000, 4'h2, 1'b0, 8'h00, 4'h2, 1'b1}, // R3 enabled borrow
    {16'h0000, 16'h0000, 4'h2, 1'b0, 8'h00, 4'h4, 1'b0}, // R3 disabled borrow
    {16'h0000, 16'h0000, 4'hF, 1'b1, 8'h00, 4'h8, 1'b0}, // R3 R4
    {16'h5555, 16'h0000, 4'h0, 1'b0, 8'hFF, 4'h0, 1'b1}, // R1 wide AND
    {16'h5555, 16'h0000, 4'h0, 1'b0, 8'hFE, 4'h0, 1'b0}, // R1
    {16'h0002, 16'h0000, 4'h0, 1'b1, 8'h00, 4'h0, 1'b0}  // R1 complement, R4
  };

  function automatic logic [87:0] mk(input logic [15:0] m0, m1, m2, m3, m4,
      input logic [3:0] sen, input logic pol, input logic [1:0] mode, input logic osel);
    return {osel, mode, pol, sen, m4, m3, m2, m1, m0};
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    // combinational vectors, D mode, out_sel 0
    for (int i = 0; i < 14; i++) begin
      cfg   = mk(VEC[i][49:34], VEC[i][33:18], 16'h0, 16'h0, 16'h0,
                 VEC[i][17:14], VEC[i][13], 2'b00, 1'b0);
      in_v  = VEC[i][12:5];
      shr_v = VEC[i][4:1];
      #1;
      chk($sformatf("R1-vec%0d", i), out, VEC[i][0]);
    end

    // R11 sharing output, in JK mode so term 4 must still appear
    cfg  = mk(16'h0001, 16'h0002, 16'h0000, 16'h0010, 16'h0008, 4'h0, 1'b0, 2'b10, 1'b0);
    in_v = 8'h05; shr_v = 4'h0;
    #1;
    n_chk++;
    if (pt !== 5'b11001) begin
      n_err++;
      $display("FAIL R11: got %b expected %b", pt, 5'b11001);
    end
    // R8 term 4 excluded from the sum in JK mode; R2 included in D mode
    cfg  = mk(16'h0, 16'h0, 16'h0, 16'h0, 16'h0001, 4'h0, 1'b0, 2'b10, 1'b0);
    in_v = 8'h01;
    #1 chk("R8 k-term removed", out, 1'b0);
    cfg[86:85] = 2'b00;
    #1 chk("R2 term4 in sum", out, 1'b1);

    // R10 reset holds stored value at 0 with D input 1
    cfg = mk(16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0, 1'b1, 2'b00, 1'b1);
    in_v = 8'h00;
    step(); step();
    chk("R10 reset", out, 1'b0);
    rst_ni = 1'b1;
    step(); chk("R6 D load 1", out, 1'b1);
    cfg[84] = 1'b0;
    step(); chk("R6 D load 0", out, 1'b0);
    chk("R5 out_sel registered", out, 1'b0);

    // R7 toggle mode
    cfg[86:85] = 2'b01; cfg[84] = 1'b1;
    step(); chk("R7 toggle up", out, 1'b1);
    step(); chk("R7 toggle down", out, 1'b0);
    step(); chk("R7 toggle up again", out, 1'b1);
    cfg[84] = 1'b0;
    step(); chk("R7 hold", out, 1'b1);

    // R8 JK: K = term 4 = in0
    cfg = mk(16'h0, 16'h0, 16'h0, 16'h0, 16'h0001, 4'h0, 1'b1, 2'b10, 1'b1);
    in_v = 8'h01;
    step(); chk("R8 toggle 1->0", out, 1'b0);
    step(); chk("R8 toggle 0->1", out, 1'b1);
    cfg[84] = 1'b0;
    step(); chk("R8 reset", out, 1'b0);
    cfg[84] = 1'b1; in_v = 8'h00;
    step(); chk("R8 set", out, 1'b1);
    cfg[84] = 1'b0;
    step(); chk("R8 hold", out, 1'b1);

    // R9 latch mode
    cfg = mk(16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0, 1'b0, 2'b11, 1'b1);
    step(); chk("R9 follow high 0", out, 1'b0);
    #0.2 cfg[84] = 1'b1;
    #0.3 chk("R9 follow high 1", out, 1'b1);
    #1.5 cfg[84] = 1'b0;
    #0.5 chk("R9 hold low", out, 1'b1);
    step(); chk("R9 follow next high", out, 1'b0);

    // R10 asynchronous clear in D and latch modes
    cfg = mk(16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0, 1'b1, 2'b00, 1'b1);
    step(); chk("R6 D before clear", out, 1'b1);
    #0.2 rst_ni = 1'b0;
    #0.3 chk("R10 async clear D", out, 1'b0);
    cfg[86:85] = 2'b11;
    step(); chk("R10 clear latch", out, 1'b0);
    cfg[87] = 1'b0;
    #0.2 chk("R5 comb during reset", out, 1'b1);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule